// File: doc/BRIEF.md
# Store-Path Write-Miss Controller for a Set-Associative Data Cache

This block is the store side of a small level-one data cache with one to four ways. It keeps the tag state and the line data of every set. For each store it decides whether the line is present and writable (a hit), present but only readable (an upgrade), or absent (a true miss). On a hit it merges the store into the line. On an upgrade or a true miss it asks a miss table for an entry and then asks the next level for ownership, and it reports one result code for the store.

A true miss takes the least-recently-used way of the set as its victim. If that victim holds a writable line, its contents go out on a writeback port first. The victim tag is then cleared before the fetch starts. Store-conditional accesses are never queued in the write buffer. They only go out on a true miss when the cache is direct-mapped or bypassed and the link flag is set. A stalled ordinary store can instead be handed to an external write buffer when that buffer has room. Lines arrive through a separate fill port.

Top module: `wm_store_ctrl`

## Requirements
- R1: The lookup first searches the ways, lowest index first, for a valid writable line whose tag matches. This is a hit. If there is none, it searches the same way for a valid line whose tag matches, which is an upgrade. Anything else is a true miss.
- R2: Each set keeps a full recency order. After reset, way WAYS-1 is the least recent and way 0 the most recent. A hit and a store that completes at once both make their way the most recent. A true miss picks the least recent way as its victim. Fills do not change the order.
- R3: An ordinary store raises mt_alloc. On an upgrade it sends miss_cmd 1 (ownership upgrade). On a true miss it sends miss_cmd 0 (get exclusive).
- R4: A store-conditional that finds its line present but not writable raises mt_alloc with miss_cmd 2 (conditional upgrade).
- R5: A store-conditional on a true miss returns SC-failure (code 3) with no allocation. The exception is when the link flag is set and the cache is direct-mapped (WAYS==1) or bypassed (L1_BYPASS!=0). In that case it allocates with miss_cmd 0.
- R6: The miss-table status is 0 ok, 1 full, 2 conflict or 3 merge. On full or conflict, an ordinary store returns stall (code 1) and a store-conditional returns SC-failure. On merge the store takes the stall path of R9. Only status ok leads to nl_req.
- R7: A successful allocation (status ok) whose victim is a valid writable line raises wb_valid one cycle later. wb_addr is the victim line address with a zero offset, and wb_line holds its bytes.
- R8: A true miss with status ok clears the victim's valid bit. A later store to that old line misses, unless a completion or a fill installs the line again.
- R9: On the stall path (merge, or next-level status 0 pending), an ordinary store with wbuf_space raises wbuf_push and returns success (code 0). Without space it returns stall. A store-conditional always returns stall and never pushes.
- R10: A hit writes 1<<req_size bytes (size 0..3 gives 1, 2, 4 or 8 bytes) into the line. The write starts at the offset held in the low address bits. Bytes come from the low end of req_data, lowest byte to the lowest address.
- R11: rsp_valid is high exactly in the cycle after a cycle with req_valid. rsp_code is 0 success, 1 stall, 2 failure, 3 SC-failure or 4 bus error.
- R12: The next-level status is 0 pending, 1 done, 2 retry or 3 bus error. Retry raises mt_free and returns failure. Bus error raises mt_free and returns bus error. Done makes the line valid and writable, merges the store as in R10 and returns success.
- R13: A fill with no request in the same cycle writes the tag, the writable bit and the whole line into the named way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Store request this cycle |
| req_sc | input | 1 | Store is a store-conditional |
| req_link | input | 1 | Link flag of the issuing core |
| req_addr | input | ADDR_W | Byte address of the store |
| req_size | input | 2 | Log2 of the store size in bytes |
| req_data | input | 64 | Store data, low bytes used |
| mt_alloc | output | 1 | Miss-table allocation request |
| miss_cmd | output | 2 | Ownership command for the next level |
| mt_status | input | 2 | Same-cycle miss-table answer |
| nl_req | output | 1 | Fetch request to the next level |
| nl_status | input | 2 | Same-cycle next-level answer |
| mt_free | output | 1 | Release the allocated miss entry |
| wbuf_space | input | 1 | Write buffer can take a store |
| wbuf_push | output | 1 | Hand the current store to the write buffer |
| fill_valid | input | 1 | Install a line (ignored when req_valid) |
| fill_line_addr | input | ADDR_W-OFF_W | Line address of the fill |
| fill_way | input | WAY_W | Way that receives the fill |
| fill_excl | input | 1 | Filled line is writable |
| fill_data | input | LINE_BYTES*8 | Fill line contents |
| wb_valid | output | 1 | Writeback of a dirty victim |
| wb_addr | output | ADDR_W | Victim line address |
| wb_line | output | LINE_BYTES*8 | Victim line contents |
| rsp_valid | output | 1 | Result valid |
| rsp_code | output | 3 | Result code |

## Verification
The main instance is built with four sets of four 16-byte ways and 16-bit addresses. Six random tags per set are enough to force regular evictions, so the recency order, dirty writebacks and store merging all become visible through wb_line. A second instance uses one way per set. Only there can the direct-mapped path let a linked store-conditional miss go out as get-exclusive, while the four-way instance rejects the same access.

// File: rtl/wm_pkg.sv
// Shared encodings of the store write-miss controller.
// Assumes: all users import this package; widths are fixed by the port contract.
package wm_pkg;
    typedef enum logic [2:0] {
        RC_SUCCESS = 3'd0,
        RC_STALL   = 3'd1,
        RC_FAIL    = 3'd2,
        RC_SCFAIL  = 3'd3,
        RC_BUSERR  = 3'd4
    } rsp_code_e;

    typedef enum logic [1:0] {
        MC_GETX  = 2'd0,
        MC_UPG   = 2'd1,
        MC_SCUPG = 2'd2,
        MC_NONE  = 2'd3
    } miss_cmd_e;

    typedef enum logic [1:0] {
        MT_OK       = 2'd0,
        MT_FULL     = 2'd1,
        MT_CONFLICT = 2'd2,
        MT_MERGE    = 2'd3
    } mt_status_e;

    typedef enum logic [1:0] {
        NL_PENDING = 2'd0,
        NL_DONE    = 2'd1,
        NL_RETRY   = 2'd2,
        NL_BUSERR  = 2'd3
    } nl_status_e;
endpackage

// File: rtl/wm_tag_match.sv
// Tag comparison for one set: finds the first writable match (hit) and the
// first valid match of any kind (present). Purely combinational.
// Assumes: a line address sits in at most one way of a set.
module wm_tag_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 10,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  lookup_en,
    input  logic [WAYS-1:0]       way_valid,
    input  logic [WAYS-1:0]       way_excl,
    input  logic [WAYS*TAG_W-1:0] way_tags,
    input  logic [TAG_W-1:0]      lookup_tag,
    output logic                  hit,
    output logic [WAY_W-1:0]      hit_way,
    output logic                  present,
    output logic [WAY_W-1:0]      present_way
);
    logic [WAYS-1:0] match_vec;
    logic [WAYS-1:0] wr_match_vec;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match_vec[w]    = way_valid[w] && (way_tags[w*TAG_W +: TAG_W] == lookup_tag);
        assign wr_match_vec[w] = match_vec[w] && way_excl[w];
    end

    // Lowest-index priority encoders for hit and present.
    always_comb begin
        hit         = |wr_match_vec;
        present     = |match_vec;
        hit_way     = '0;
        present_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (wr_match_vec[w]) hit_way = WAY_W'(w);
            if (match_vec[w])    present_way = WAY_W'(w);
        end
    end

    assert_single_copy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        lookup_en |-> $onehot0(match_vec));
endmodule

// File: rtl/wm_lru.sv
// Per-set recency order kept as distinct ages (0 newest, WAYS-1 oldest).
// Touching a way ages every younger way by one and makes it newest.
// Assumes: touch_way is below WAYS.
module wm_lru #(
    parameter int SETS = 4,
    parameter int WAYS = 4,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_set,
    input  logic [WAY_W-1:0] touch_way,
    input  logic [IDX_W-1:0] query_set,
    output logic [WAY_W-1:0] victim_way
);
    localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

    logic [WAY_W-1:0] age_q [SETS][WAYS];

    // Reset to age = way index, update ages on a touch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    age_q[s][w] <= WAY_W'(w);
        end else if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == touch_way)
                    age_q[touch_set][w] <= '0;
                else if (age_q[touch_set][w] < age_q[touch_set][touch_way])
                    age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
            end
        end
    end

    // Victim is the way holding the oldest age.
    always_comb begin
        victim_way = '0;
        for (int w = 0; w < WAYS; w++)
            if (age_q[query_set][w] == OLDEST) victim_way = WAY_W'(w);
    end

    for (genvar s = 0; s < SETS; s++) begin : g_chk
        logic [WAYS-1:0] oldest_vec;
        for (genvar w = 0; w < WAYS; w++) begin : g_w
            assign oldest_vec[w] = (age_q[s][w] == OLDEST);
        end
        assert_one_oldest_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(oldest_vec) == 1);
    end
endmodule

// File: rtl/wm_line_store.sv
// Line data array: whole-line fill, sized byte merge of a store, and a
// combinational read of one line for writeback.
// Assumes: stores are naturally aligned and LINE_BYTES is at least 8.
module wm_line_store #(
    parameter int SETS       = 4,
    parameter int WAYS       = 4,
    parameter int LINE_BYTES = 16,
    localparam int IDX_W     = $clog2(SETS),
    localparam int WAY_W     = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int LINE_BITS = LINE_BYTES * 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fill_en,
    input  logic [IDX_W-1:0]     fill_set,
    input  logic [WAY_W-1:0]     fill_way,
    input  logic [LINE_BITS-1:0] fill_data,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_set,
    input  logic [WAY_W-1:0]     wr_way,
    input  logic [OFF_W-1:0]     wr_off,
    input  logic [1:0]           wr_size,
    input  logic [63:0]          wr_data,
    output logic [LINE_BITS-1:0] rd_line
);
    logic [LINE_BITS-1:0] mem_q [SETS*WAYS];
    logic [LINE_BITS-1:0] merged;
    int                   wr_idx;
    int                   fill_idx;

    assign wr_idx   = int'(wr_set) * WAYS + int'(wr_way);
    assign fill_idx = int'(fill_set) * WAYS + int'(fill_way);
    assign rd_line  = mem_q[wr_idx];

    // Merge the store bytes into the current line contents.
    always_comb begin
        merged = mem_q[wr_idx];
        for (int b = 0; b < LINE_BYTES; b++) begin
            if (b >= int'(wr_off) && b < int'(wr_off) + (1 << wr_size))
                merged[8*b +: 8] = 8'(wr_data >> (8 * (b - int'(wr_off))));
        end
    end

    // Clear on reset, then take fills and merged stores.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SETS*WAYS; i++) mem_q[i] <= '0;
        end else if (fill_en) begin
            mem_q[fill_idx] <= fill_data;
        end else if (wr_en) begin
            mem_q[wr_idx] <= merged;
        end
    end
endmodule

// File: rtl/wm_store_ctrl.sv
// Store-side controller of a set-associative data cache: classifies each
// store, picks a way, issues the ownership command, drives miss-table and
// next-level handshakes, writes back dirty victims and merges store data.
// Assumes: miss-table and next-level answers arrive in the request cycle;
// fills never coincide with requests (a fill in a request cycle is dropped).
module wm_store_ctrl
    import wm_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int SETS       = 4,
    parameter int WAYS       = 4,
    parameter int LINE_BYTES = 16,
    parameter int L1_BYPASS  = 0,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int IDX_W     = $clog2(SETS),
    localparam int TAG_W     = ADDR_W - OFF_W - IDX_W,
    localparam int WAY_W     = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int LINE_BITS = LINE_BYTES * 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_sc,
    input  logic                    req_link,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [1:0]              req_size,
    input  logic [63:0]             req_data,
    output logic                    mt_alloc,
    output logic [1:0]              miss_cmd,
    input  logic [1:0]              mt_status,
    output logic                    nl_req,
    input  logic [1:0]              nl_status,
    output logic                    mt_free,
    input  logic                    wbuf_space,
    output logic                    wbuf_push,
    input  logic                    fill_valid,
    input  logic [ADDR_W-OFF_W-1:0] fill_line_addr,
    input  logic [WAY_W-1:0]        fill_way,
    input  logic                    fill_excl,
    input  logic [LINE_BITS-1:0]    fill_data,
    output logic                    wb_valid,
    output logic [ADDR_W-1:0]       wb_addr,
    output logic [LINE_BITS-1:0]    wb_line,
    output logic                    rsp_valid,
    output logic [2:0]              rsp_code
);
    localparam bit SC_FALLBACK = (WAYS == 1) || (L1_BYPASS != 0);

    logic [WAYS-1:0]       tv_q [SETS];
    logic [WAYS-1:0]       tx_q [SETS];
    logic [WAYS*TAG_W-1:0] tt_q [SETS];

    logic [IDX_W-1:0] idx;
    logic [TAG_W-1:0] tag;
    logic [IDX_W-1:0] fill_set;
    logic [TAG_W-1:0] fill_tag;
    logic             fill_en;
    logic             hit, present;
    logic [WAY_W-1:0] hit_way, present_way, lru_victim, use_way;
    logic [LINE_BITS-1:0] rd_line;

    rsp_code_e  code;
    mt_status_e mts;
    nl_status_e nls;
    logic stall_path, do_wb, do_inval, do_install, do_write;

    assign idx      = req_addr[OFF_W +: IDX_W];
    assign tag      = req_addr[ADDR_W-1 -: TAG_W];
    assign fill_set = fill_line_addr[IDX_W-1:0];
    assign fill_tag = fill_line_addr[ADDR_W-OFF_W-1 -: TAG_W];
    assign fill_en  = fill_valid && !req_valid;
    assign mts      = mt_status_e'(mt_status);
    assign nls      = nl_status_e'(nl_status);
    assign use_way  = hit ? hit_way : (present ? present_way : lru_victim);

    wm_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
        .clk(clk), .rst_n(rst_n), .lookup_en(req_valid),
        .way_valid(tv_q[idx]), .way_excl(tx_q[idx]), .way_tags(tt_q[idx]),
        .lookup_tag(tag), .hit(hit), .hit_way(hit_way),
        .present(present), .present_way(present_way)
    );

    wm_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
        .clk(clk), .rst_n(rst_n), .touch_en(do_write),
        .touch_set(idx), .touch_way(use_way),
        .query_set(idx), .victim_way(lru_victim)
    );

    wm_line_store #(.SETS(SETS), .WAYS(WAYS), .LINE_BYTES(LINE_BYTES)) u_store (
        .clk(clk), .rst_n(rst_n),
        .fill_en(fill_en), .fill_set(fill_set), .fill_way(fill_way), .fill_data(fill_data),
        .wr_en(do_write), .wr_set(idx), .wr_way(use_way),
        .wr_off(req_addr[OFF_W-1:0]), .wr_size(req_size), .wr_data(req_data),
        .rd_line(rd_line)
    );

    // Classify the store and decide command, handshakes and result.
    always_comb begin
        code       = RC_SUCCESS;
        mt_alloc   = 1'b0;
        miss_cmd   = MC_NONE;
        nl_req     = 1'b0;
        mt_free    = 1'b0;
        wbuf_push  = 1'b0;
        stall_path = 1'b0;
        do_wb      = 1'b0;
        do_inval   = 1'b0;
        do_install = 1'b0;
        do_write   = 1'b0;
        if (req_valid) begin
            if (hit) begin
                do_write = 1'b1;
            end else if (req_sc && !present && !(SC_FALLBACK && req_link)) begin
                code = RC_SCFAIL;
            end else begin
                mt_alloc = 1'b1;
                miss_cmd = !present ? MC_GETX : (req_sc ? MC_SCUPG : MC_UPG);
                case (mts)
                    MT_FULL, MT_CONFLICT: code = req_sc ? RC_SCFAIL : RC_STALL;
                    MT_MERGE:             stall_path = 1'b1;
                    default: begin
                        nl_req   = 1'b1;
                        do_wb    = tv_q[idx][use_way] && tx_q[idx][use_way];
                        do_inval = !present;
                        case (nls)
                            NL_RETRY:  begin mt_free = 1'b1; code = RC_FAIL;   end
                            NL_BUSERR: begin mt_free = 1'b1; code = RC_BUSERR; end
                            NL_DONE:   begin do_install = 1'b1; do_write = 1'b1; end
                            default:   stall_path = 1'b1;
                        endcase
                    end
                endcase
                if (stall_path) begin
                    if (!req_sc && wbuf_space) wbuf_push = 1'b1;
                    else                       code = RC_STALL;
                end
            end
        end
    end

    // Tag state: clear on reset, then fills, invalidations and installs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                tv_q[s] <= '0;
                tx_q[s] <= '0;
                tt_q[s] <= '0;
            end
        end else if (fill_en) begin
            tv_q[fill_set][fill_way] <= 1'b1;
            tx_q[fill_set][fill_way] <= fill_excl;
            tt_q[fill_set][fill_way*TAG_W +: TAG_W] <= fill_tag;
        end else if (req_valid) begin
            if (do_inval) tv_q[idx][use_way] <= 1'b0;
            if (do_install) begin
                tv_q[idx][use_way] <= 1'b1;
                tx_q[idx][use_way] <= 1'b1;
                tt_q[idx][use_way*TAG_W +: TAG_W] <= tag;
            end
        end
    end

    // Register the result and the victim writeback.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_code  <= RC_SUCCESS;
            wb_valid  <= 1'b0;
            wb_addr   <= '0;
            wb_line   <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_code  <= code;
            wb_valid  <= req_valid && do_wb;
            if (req_valid && do_wb) begin
                wb_addr <= {tt_q[idx][use_way*TAG_W +: TAG_W], idx, {OFF_W{1'b0}}};
                wb_line <= rd_line;
            end
        end
    end

    assert_rsp_follows_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));
    assert_code_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_code <= 3'd4));
    assert_wb_after_alloc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> ($past(mt_alloc) && $past(mt_status) == 2'd0));
    assert_sc_not_buffered_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_sc) |-> !wbuf_push);
endmodule

// File: tb/wm_store_ctrl_tb.sv
module wm_store_ctrl_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic         req_valid = 0, req_sc = 0, req_link = 0;
    logic [15:0]  req_addr = '0;
    logic [1:0]   req_size = '0;
    logic [63:0]  req_data = '0;
    logic [1:0]   mt_status = '0, nl_status = '0;
    logic         wbuf_space = 0;
    logic         fill_valid = 0, fill_excl = 0;
    logic [11:0]  fill_line_addr = '0;
    logic [1:0]   fill_way = '0;
    logic [127:0] fill_data = '0;

    logic         mt_alloc, nl_req, mt_free, wbuf_push, wb_valid, rsp_valid;
    logic [1:0]   miss_cmd;
    logic [15:0]  wb_addr;
    logic [127:0] wb_line;
    logic [2:0]   rsp_code;

    logic         dm_alloc, dm_nl, dm_free, dm_push, dm_wbv, dm_rspv;
    logic [1:0]   dm_cmd;
    logic [15:0]  dm_wba;
    logic [127:0] dm_wbl;
    logic [2:0]   dm_code;

    wm_store_ctrl #(.ADDR_W(16), .SETS(4), .WAYS(4), .LINE_BYTES(16), .L1_BYPASS(0)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sc(req_sc), .req_link(req_link),
        .req_addr(req_addr), .req_size(req_size), .req_data(req_data),
        .mt_alloc(mt_alloc), .miss_cmd(miss_cmd), .mt_status(mt_status),
        .nl_req(nl_req), .nl_status(nl_status), .mt_free(mt_free),
        .wbuf_space(wbuf_space), .wbuf_push(wbuf_push),
        .fill_valid(fill_valid), .fill_line_addr(fill_line_addr), .fill_way(fill_way),
        .fill_excl(fill_excl), .fill_data(fill_data),
        .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_line(wb_line),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code)
    );

    wm_store_ctrl #(.ADDR_W(16), .SETS(4), .WAYS(1), .LINE_BYTES(16), .L1_BYPASS(0)) u_dut_dm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sc(req_sc), .req_link(req_link),
        .req_addr(req_addr), .req_size(req_size), .req_data(req_data),
        .mt_alloc(dm_alloc), .miss_cmd(dm_cmd), .mt_status(mt_status),
        .nl_req(dm_nl), .nl_status(nl_status), .mt_free(dm_free),
        .wbuf_space(wbuf_space), .wbuf_push(dm_push),
        .fill_valid(1'b0), .fill_line_addr(fill_line_addr), .fill_way(1'b0),
        .fill_excl(fill_excl), .fill_data(fill_data),
        .wb_valid(dm_wbv), .wb_addr(dm_wba), .wb_line(dm_wbl),
        .rsp_valid(dm_rspv), .rsp_code(dm_code)
    );

    int n_chk = 0;
    int n_err = 0;

    // Model of the four-way instance
    bit           mv [4][4];
    bit           mx [4][4];
    logic [9:0]   mt [4][4];
    logic [127:0] md [4][4];
    int           mage [4][4];

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic void model_reset();
        for (int s = 0; s < 4; s++)
            for (int w = 0; w < 4; w++) begin
                mv[s][w] = 0; mx[s][w] = 0; mt[s][w] = '0; md[s][w] = '0; mage[s][w] = w;
            end
    endfunction

    function automatic void touch(int s, int w);
        int a = mage[s][w];
        for (int u = 0; u < 4; u++) begin
            if (u == w) mage[s][u] = 0;
            else if (mage[s][u] < a) mage[s][u]++;
        end
    endfunction

    task automatic do_fill(input int s, input logic [9:0] tg, input bit ex, input logic [127:0] line);
        int w = -1;
        for (int u = 0; u < 4; u++) if (w < 0 && mv[s][u] && mt[s][u] == tg) w = u;
        if (w < 0) w = int'($urandom % 4);
        @(negedge clk);
        fill_valid = 1; fill_line_addr = {tg, 2'(s)}; fill_way = 2'(w);
        fill_excl = ex; fill_data = line;
        @(negedge clk);
        fill_valid = 0;
        mv[s][w] = 1; mx[s][w] = ex; mt[s][w] = tg; md[s][w] = line;   // R13
    endtask

    task automatic do_store(input bit sc, input bit link, input logic [15:0] addr,
                            input logic [1:0] sz, input logic [63:0] data,
                            input logic [1:0] mts, input logic [1:0] nls, input bit space);
        int s = int'(addr[5:4]);
        logic [9:0] tg = addr[15:6];
        int off = int'(addr[3:0]);
        int hw = -1, pw = -1, v = 0;
        bit e_alloc = 0, e_nl = 0, e_free = 0, e_push = 0, e_wb = 0, e_write = 0, stallp = 0;
        logic [1:0] e_cmd = 2'd3;
        logic [2:0] e_code = 3'd0;
        logic [15:0] e_wba = '0;
        logic [127:0] e_wbl = '0;
        for (int u = 0; u < 4; u++) begin
            if (hw < 0 && mv[s][u] && mx[s][u] && mt[s][u] == tg) hw = u;
            if (pw < 0 && mv[s][u] && mt[s][u] == tg) pw = u;
        end
        if (hw >= 0) v = hw;
        else if (pw >= 0) v = pw;
        else for (int u = 0; u < 4; u++) if (mage[s][u] == 3) v = u;
        if (hw >= 0) e_write = 1;
        else if (sc && pw < 0) e_code = 3'd3;                 // R5: four-way, no fallback
        else begin
            e_alloc = 1;
            e_cmd = (pw < 0) ? 2'd0 : (sc ? 2'd2 : 2'd1);
            if (mts == 2'd1 || mts == 2'd2) e_code = sc ? 3'd3 : 3'd1;
            else if (mts == 2'd3) stallp = 1;
            else begin
                e_nl = 1;
                if (mv[s][v] && mx[s][v]) begin
                    e_wb = 1; e_wba = {mt[s][v], 2'(s), 4'b0}; e_wbl = md[s][v];
                end
                if (pw < 0) mv[s][v] = 0;                      // R8
                if (nls == 2'd2) begin e_free = 1; e_code = 3'd2; end
                else if (nls == 2'd3) begin e_free = 1; e_code = 3'd4; end
                else if (nls == 2'd1) begin
                    e_write = 1; mv[s][v] = 1; mx[s][v] = 1; mt[s][v] = tg;
                end else stallp = 1;
            end
            if (stallp) begin
                if (!sc && space) e_push = 1;
                else e_code = 3'd1;
            end
        end
        if (e_write) begin
            for (int b = 0; b < (1 << sz); b++) md[s][v][8*(off+b) +: 8] = data[8*b +: 8];
            touch(s, v);
        end
        @(negedge clk);
        req_valid = 1; req_sc = sc; req_link = link; req_addr = addr; req_size = sz;
        req_data = data; mt_status = mts; nl_status = nls; wbuf_space = space;
        #1;
        chk(mt_alloc == e_alloc, "R3", "mt_alloc", 128'(mt_alloc), 128'(e_alloc));
        if (e_alloc) chk(miss_cmd == e_cmd, sc ? "R4" : "R3", "miss_cmd", 128'(miss_cmd), 128'(e_cmd));
        chk(nl_req == e_nl, "R6", "nl_req", 128'(nl_req), 128'(e_nl));
        chk(mt_free == e_free, "R12", "mt_free", 128'(mt_free), 128'(e_free));
        chk(wbuf_push == e_push, "R9", "wbuf_push", 128'(wbuf_push), 128'(e_push));
        @(negedge clk);
        req_valid = 0;
        chk(rsp_valid == 1'b1, "R11", "rsp_valid", 128'(rsp_valid), 128'(1));
        chk(rsp_code == e_code, "R11", "rsp_code", 128'(rsp_code), 128'(e_code));
        chk(wb_valid == e_wb, "R7", "wb_valid", 128'(wb_valid), 128'(e_wb));
        if (e_wb) begin
            chk(wb_addr == e_wba, "R7", "wb_addr", 128'(wb_addr), 128'(e_wba));
            chk(wb_line == e_wbl, "R10", "wb_line", wb_line, e_wbl);
        end
    endtask

    initial begin
        #(8 * 200000);
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0017));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(rsp_valid == 0, "R11", "reset rsp_valid", 128'(rsp_valid), 128'(0));
        chk(wb_valid == 0, "R7", "reset wb_valid", 128'(wb_valid), 128'(0));

        // R5: linked SC true miss, four-way rejects, direct-mapped allocates GETX
        @(negedge clk);
        req_valid = 1; req_sc = 1; req_link = 1; req_addr = 16'h0040; req_size = 2;
        mt_status = 2'd1; nl_status = 0;
        #1;
        chk(mt_alloc == 0, "R5", "4-way SC miss alloc", 128'(mt_alloc), 128'(0));
        chk(dm_alloc == 1, "R5", "dm SC miss alloc", 128'(dm_alloc), 128'(1));
        chk(dm_cmd == 2'd0, "R5", "dm SC miss cmd", 128'(dm_cmd), 128'(0));
        req_link = 0;
        #1;
        chk(dm_alloc == 0, "R5", "dm SC unlinked alloc", 128'(dm_alloc), 128'(0));
        @(negedge clk);
        req_valid = 0;
        chk(rsp_code == 3'd3, "R5", "4-way SC miss code", 128'(rsp_code), 128'(3));
        chk(dm_code == 3'd3, "R5", "dm SC unlinked code", 128'(dm_code), 128'(3));

        // Directed: miss/complete, hit writes, upgrade, SC upgrade, evictions
        do_store(0, 0, {10'd1, 2'd0, 4'd0}, 2'd0, 64'hA5, 2'd0, 2'd1, 0);     // R12 done
        do_store(0, 0, {10'd1, 2'd0, 4'd8}, 2'd3, 64'h1122334455667788, 2'd0, 2'd0, 0); // R10 hit
        do_store(0, 0, {10'd1, 2'd0, 4'd2}, 2'd1, 64'hBEEF, 2'd0, 2'd0, 0);
        do_fill(0, 10'd2, 0, 128'hCAFE);
        do_store(0, 0, {10'd2, 2'd0, 4'd4}, 2'd2, 64'hDEAD, 2'd1, 2'd0, 0);  // R3 upgrade, full
        do_fill(1, 10'd3, 0, 128'h77);
        do_store(1, 1, {10'd3, 2'd1, 4'd0}, 2'd2, 64'h9, 2'd0, 2'd1, 0);      // R4 SC upgrade
        do_store(0, 0, {10'd4, 2'd0, 4'd0}, 2'd0, 64'h1, 2'd3, 2'd0, 1);      // R9 merge pushed
        do_store(1, 0, {10'd4, 2'd0, 4'd0}, 2'd0, 64'h1, 2'd0, 2'd0, 1);      // R9 SC not pushed
        for (int t = 5; t < 11; t++)                                          // R2/R7 eviction
            do_store(0, 0, {10'(t), 2'd3, 4'd0}, 2'd2, 64'(t * 3), 2'd0, 2'd1, 0);
        do_store(0, 0, {10'd5, 2'd3, 4'd0}, 2'd0, 64'h0, 2'd0, 2'd2, 0);      // R8/R12 retry
        do_store(0, 0, {10'd6, 2'd3, 4'd0}, 2'd0, 64'h0, 2'd0, 2'd3, 0);      // R12 bus error

        // Random mix
        for (int i = 0; i < 2500; i++) begin
            int s = int'($urandom % 4);
            logic [9:0] tg = 10'($urandom % 6);
            if ($urandom % 4 == 0) begin
                do_fill(s, tg, bit'($urandom % 2), {$urandom, $urandom, $urandom, $urandom});
            end else begin
                logic [1:0] sz = 2'($urandom % 4);
                int nb = 1 << sz;
                int off = int'($urandom % (16 / nb)) * nb;
                int r = int'($urandom % 10);
                logic [1:0] mts = (r < 6) ? 2'd0 : 2'(r - 6);
                do_store(bit'($urandom % 5 == 0), bit'($urandom % 2),
                         {tg, 2'(s), 4'(off)}, sz, {$urandom, $urandom},
                         mts, 2'($urandom % 4), bit'($urandom % 2));
            end
        end

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule